// File: doc/BRIEF.md
# Frequency Lock Detector

This block decides whether a recovered full-rate clock runs at the frequency implied by a slower reference clock. The reference arrives at either 1/64 or 1/16 of the recovered rate. A static select pin says which. In the 1/16 case the reference first passes through a divide-by-4, so the comparison always runs at 1/64 of the recovered rate.

The processed reference defines a fixed measurement window of 2^WIN_LOG2 cycles. Each time a window closes, a toggle crosses into the recovered-clock domain through a two-flop synchronizer. There, a free-running divide-by-64 of the recovered clock has been counted since the previous boundary. The count is compared with the ideal value plus or minus TOL. With the defaults (4096 and 4) that is a tolerance of about ±1000 ppm. The result drives an active-low loss-of-lock output, `lol_n`, which is 1 when the clocks are locked.

A small state machine in the recovered domain sequences the measurement. ST_ALIGN waits for the first window boundary after reset and discards the partial window (transition ALIGN to MEASURE on a boundary). ST_MEASURE counts; a boundary moves it to ST_JUDGE and snapshots the count (MEASURE to JUDGE). ST_JUDGE updates the flag and returns to ST_MEASURE on the next cycle (JUDGE to MEASURE), or stays in ST_JUDGE if another boundary arrives at once.

Top module: `freq_lock_det`

## Requirements
- R1: While reset is asserted `lol_n` is 0. After reset it stays 0 until the end of the first complete window; the partial window that follows reset is discarded.
- R2: With `ref_div_sel` = 0 each reference cycle is one window cycle, so a window lasts 2^WIN_LOG2 reference cycles.
- R3: With `ref_div_sel` = 1 the reference is divided by 4 first, so a window lasts 4·2^WIN_LOG2 reference cycles. The wrong selection for a given reference frequency gives loss of lock.
- R4: In each window the number of recovered-clock/64 periods is counted. The window is in lock when that count lies in [2^WIN_LOG2 − TOL, 2^WIN_LOG2 + TOL], with both limits included; the count saturates and never wraps.
- R5: A recovered clock fast enough that the count exceeds the upper limit drives `lol_n` to 0.
- R6: A recovered clock slow enough that the count falls below the lower limit drives `lol_n` to 0.
- R7: `lol_n` changes only at the evaluation that follows a window boundary and holds its value between evaluations.
- R8: The window boundary crosses into the recovered domain as a toggle through a two-flop synchronizer, and `lol_n` changes only on a rising edge of `rec_clk` (apart from reset).
- R9: After a loss of lock, a return to an in-tolerance frequency sets `lol_n` back to 1 within two windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, synchronized into both clock domains |
| rec_clk | input | 1 | Recovered full-rate clock |
| ref_clk | input | 1 | Low-speed reference clock |
| ref_div_sel | input | 1 | Static: 0 = reference is 1/64 of rec_clk, 1 = reference is 1/16 of rec_clk and is divided by 4 |
| lol_n | output | 1 | Loss of lock, active low (1 = locked) |

## Verification
On every cycle the assertions check these properties:
- the flag holds between evaluations;
- the machine is unlocked while it aligns;
- a judgement follows a synchronized boundary;
- the period count never decreases inside a window;
- the divided reference ticks at most once in two cycles;
- the window toggle flips only when its counter wraps.

Only the bench scenarios can show the frequency decision itself. They sweep the recovered-clock period through nominal, both limits and both out-of-tolerance sides in each prescale mode, apply a mismatched prescale selection, and check relocking.

// File: rtl/lkd_pkg.sv
`timescale 1ns/1ps
package lkd_pkg;
    typedef enum logic [1:0] {
        ST_ALIGN   = 2'd0,
        ST_MEASURE = 2'd1,
        ST_JUDGE   = 2'd2
    } meter_state_t;
endpackage

// File: rtl/lkd_rst_sync.sv
`timescale 1ns/1ps
module lkd_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_sync_n
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lkd_ref_window.sv
`timescale 1ns/1ps
module lkd_ref_window #(
    parameter int WIN_LOG2 = 12,
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_sel,
    output logic win_tgl
);
    logic [DIV_LOG2-1:0] pre_q;
    logic [WIN_LOG2-1:0] win_q;
    logic                tgl_q;
    logic                tick;

    // One window tick per reference cycle, or one per 2^DIV_LOG2 cycles when prescaled
    assign tick = !div_sel || (&pre_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            win_q <= '0;
            tgl_q <= 1'b0;
        end else begin
            pre_q <= div_sel ? pre_q + 1'b1 : '0;
            if (tick) begin
                win_q <= win_q + 1'b1;
                if (&win_q) tgl_q <= ~tgl_q;
            end
        end
    end

    assign win_tgl = tgl_q;

    // R3: the prescaled tick is never on two consecutive cycles
    a_r3_div_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel && tick) |=> (!tick || !div_sel));

    // R2: the boundary toggle flips only at a window counter wrap
    a_r2_toggle_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tgl_q != $past(tgl_q)) |-> $past(&win_q));
endmodule

// File: rtl/lkd_edge_sync.sv
`timescale 1ns/1ps
module lkd_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic evt
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= tgl_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign evt = sync_q ^ last_q;

    // R8: each crossed boundary becomes a single-cycle event
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
endmodule

// File: rtl/lkd_rec_meter.sv
`timescale 1ns/1ps
module lkd_rec_meter
    import lkd_pkg::*;
#(
    parameter int WIN_LOG2     = 12,
    parameter int TOL          = 4,
    parameter int REC_DIV_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic win_evt,
    output logic locked
);
    localparam int CW              = WIN_LOG2 + 2;
    localparam int WIN             = 1 << WIN_LOG2;
    localparam logic [CW-1:0] LO_C = CW'(WIN - TOL);
    localparam logic [CW-1:0] HI_C = CW'(WIN + TOL);

    meter_state_t state_q, state_d;
    logic [REC_DIV_LOG2-1:0] pre_q;
    logic [CW-1:0]           div_q, snap_q;
    logic                    lock_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ALIGN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ALIGN:   if (win_evt) state_d = ST_MEASURE;
            ST_MEASURE: if (win_evt) state_d = ST_JUDGE;
            ST_JUDGE:   state_d = win_evt ? ST_JUDGE : ST_MEASURE;
            default:    state_d = ST_ALIGN;
        endcase
    end

    // Divided recovered-clock counter, restarted at each boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            div_q  <= '0;
            snap_q <= '0;
        end else if (win_evt) begin
            pre_q  <= '0;
            div_q  <= '0;
            snap_q <= div_q;
        end else begin
            pre_q <= pre_q + 1'b1;
            if ((&pre_q) && (div_q != '1)) div_q <= div_q + 1'b1;
        end
    end

    // Output process: flag moves only when judging
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  lock_q <= 1'b0;
        else if (state_q == ST_JUDGE) lock_q <= (snap_q >= LO_C) && (snap_q <= HI_C);
    end

    assign locked = lock_q;

    // R1: no lock while the first partial window is discarded
    a_r1_align_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALIGN) |-> !lock_q);

    // R7: the flag holds outside a judgement
    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_JUDGE) |=> $stable(lock_q));

    // R8: a judgement is always caused by a synchronized boundary
    a_r8_judge_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE) |-> $past(win_evt));

    // R4: the count never wraps inside a window
    a_r4_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !win_evt |=> (div_q >= $past(div_q)));
endmodule

// File: rtl/freq_lock_det.sv
`timescale 1ns/1ps
module freq_lock_det #(
    parameter int WIN_LOG2     = 12,
    parameter int TOL          = 4,
    parameter int REC_DIV_LOG2 = 6,
    parameter int REF_DIV_LOG2 = 2
) (
    input  logic rst_n,
    input  logic rec_clk,
    input  logic ref_clk,
    input  logic ref_div_sel,
    output logic lol_n
);
    logic ref_rst_n, rec_rst_n;
    logic win_tgl, win_evt, locked;

    lkd_rst_sync #(.STAGES(2)) u_rs_ref (
        .clk(ref_clk), .rst_n(rst_n), .rst_sync_n(ref_rst_n)
    );

    lkd_rst_sync #(.STAGES(2)) u_rs_rec (
        .clk(rec_clk), .rst_n(rst_n), .rst_sync_n(rec_rst_n)
    );

    lkd_ref_window #(.WIN_LOG2(WIN_LOG2), .DIV_LOG2(REF_DIV_LOG2)) u_win (
        .clk(ref_clk), .rst_n(ref_rst_n), .div_sel(ref_div_sel), .win_tgl(win_tgl)
    );

    lkd_edge_sync u_sync (
        .clk(rec_clk), .rst_n(rec_rst_n), .tgl_in(win_tgl), .evt(win_evt)
    );

    lkd_rec_meter #(.WIN_LOG2(WIN_LOG2), .TOL(TOL), .REC_DIV_LOG2(REC_DIV_LOG2)) u_meter (
        .clk(rec_clk), .rst_n(rec_rst_n), .win_evt(win_evt), .locked(locked)
    );

    assign lol_n = locked;
endmodule

// File: tb/freq_lock_det_tb.sv
`timescale 1ns/1ps
module freq_lock_det_tb;
    // Window of 64 processed-reference cycles = 4096 nominal rec cycles; lock if /64 count in [62,66]
    localparam real WT = 81920.0;

    logic rst_n = 1'b0;
    logic rec_clk = 1'b0;
    logic ref_clk = 1'b0;
    logic ref_div_sel = 1'b0;
    logic lol_n;

    real rec_half = 10.0;   // 50 MHz nominal
    real ref_half = 640.0;

    int n_tests = 0;
    int n_fail  = 0;
    int n_chg   = 0;

    always #(rec_half) rec_clk = ~rec_clk;
    always #(ref_half) ref_clk = ~ref_clk;

    freq_lock_det #(.WIN_LOG2(6), .TOL(2), .REC_DIV_LOG2(6), .REF_DIV_LOG2(2)) u_dut (
        .rst_n(rst_n), .rec_clk(rec_clk), .ref_clk(ref_clk),
        .ref_div_sel(ref_div_sel), .lol_n(lol_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: lol_n=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // R8: flag changes outside reset only right after a rising rec_clk edge
    always @(lol_n) begin
        if (rst_n === 1'b1) begin
            n_chg++;
            n_tests++;
            if (rec_clk !== 1'b1) begin
                n_fail++;
                $display("FAIL R8: lol_n changed with rec_clk=%b expected 1 at %0t", rec_clk, $time);
            end
        end
    end

    task automatic settle();
        #(2.0 * WT + 2000.0);
    endtask

    task automatic t_reset(input logic sel, input real rh, input logic exp_lock, input string req);
        rst_n = 1'b0;
        ref_div_sel = sel;
        ref_half = rh;
        rec_half = 10.0;
        #5000;
        chk("R1 in reset", lol_n, 1'b0);
        rst_n = 1'b1;
        #(1.5 * WT);
        chk("R1 partial window discarded", lol_n, 1'b0);
        #(1.0 * WT);
        chk(req, lol_n, exp_lock);
    endtask

    task automatic t_period(input real half, input logic exp_lock, input string req);
        rec_half = half;
        settle();
        chk(req, lol_n, exp_lock);
    endtask

    task automatic t_hold();
        int c0;
        rec_half = 10.0;
        settle();
        chk("R7 locked before hold", lol_n, 1'b1);
        c0 = n_chg;
        #(3.0 * WT);
        n_tests++;
        if (n_chg != c0) begin
            n_fail++;
            $display("FAIL R7: %0d changes while stable, expected 0", n_chg - c0);
        end
        rec_half = 9.5;
        #200;
        chk("R7 holds until next judgement", lol_n, 1'b1);
        settle();
        chk("R5 after hold", lol_n, 1'b0);
    endtask

    initial begin
        #3600000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R2: direct reference at 1/64 of rec_clk
        t_reset(1'b0, 640.0, 1'b1, "R2 direct mode nominal lock");
        t_period(9.5,   1'b0, "R5 fast count 67 out");
        t_period(10.0,  1'b1, "R9 relock at nominal");
        t_period(10.6,  1'b0, "R6 slow count 60 out");
        t_period(10.0,  1'b1, "R9 relock after slow");
        // R4: limits, count = floor(1280/T)
        t_period(9.625, 1'b1, "R4 upper limit 66 in");
        t_period(10.45, 1'b0, "R6 count 61 just below");
        t_period(10.25, 1'b1, "R4 lower limit 62 in");
        t_period(9.5,   1'b0, "R5 count 67 just above");
        t_hold();
        // R3: reference at 1/16 of rec_clk, divided by 4
        t_reset(1'b1, 160.0, 1'b1, "R3 prescaled mode nominal lock");
        t_period(9.5,   1'b0, "R3 R5 prescaled fast out");
        t_period(10.0,  1'b1, "R3 R9 prescaled relock");
        // R3: 1/16 reference without prescaling is out of lock
        t_reset(1'b0, 160.0, 1'b0, "R3 wrong selection unlocked");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule